// File: doc/BRIEF.md
# Buffered Baud Rate Divider

This block derives two timing strobes from the module clock for a serial port: a 16x oversampling tick and a bit-rate tick. The tick rate is set by a 13-bit divisor, so the bit rate is the module clock divided by 16 times the divisor. The divisor can be any value from 1 to 8191.

Software loads the divisor through two byte-wide writes. A write to the high byte is only staged. Both bytes become active together when the low byte is written, so the counter never runs on a half-updated value. The counter stays stopped after reset until the transmitter or receiver enable is raised for the first time. It also stops whenever the divisor is zero. A new divisor is picked up only when the running period ends.

Top module: `baud_div`

## Requirements
- R1: After reset the active divisor is 4: a read with `rdSel`=1 (low byte) returns 0x04, a read with `rdSel`=0 (high byte) returns 0x00, and neither tick pulses.
- R2: A write with `wrSel`=0 (high byte) only stores `wrData[4:0]` in a holding register. Neither byte's read-back changes until a later low-byte write.
- R3: A write with `wrSel`=1 makes the active divisor {holding[4:0], `wrData`}. The high-byte read returns divisor bits 12..8 in bits 4..0 and zero in bits 7..5. Bits 7..5 of a high-byte write are discarded.
- R4: While running with divisor D, `overTick` is a one-clock pulse once every D clocks. With D=1 it is high on every clock.
- R5: The generator is idle after reset until `txEnable` or `rxEnable` is seen high at a clock edge. After that it stays armed even if both enables drop.
- R6: While the active divisor is zero, no tick pulses.
- R7: `bitTick` pulses together with every 16th `overTick` and never without it.
- R8: A divisor written while running takes effect only after the current period completes, including a write that lands on the wrap cycle. No period is shortened or stretched.
- R9: The holding register keeps its value across low-byte writes. Repeated low-byte writes reuse the last staged high part, which is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 high byte, 1 low byte |
| wrData | input | 8 | Write data |
| rdSel | input | 1 | Read target: 0 high byte, 1 low byte |
| rdData | output | 8 | Read-back of selected divisor byte |
| txEnable | input | 1 | Transmitter enable |
| rxEnable | input | 1 | Receiver enable |
| overTick | output | 1 | Oversampling tick pulse |
| bitTick | output | 1 | Bit-rate tick pulse |

## Verification
Two events can fall in the same cycle. A low-byte divisor write can land on exactly the clock edge where the counter wraps. The bit tick also coincides with an oversampling tick. The bench times a write so that it is sampled on the wrap edge of a divisor-3 period. It then measures the next two tick gaps, which must be 3 and then 7: the wrap reloads the old value and only the following period uses the new one. Separately, every `bitTick` is checked against a concurrent `overTick`, and the oversampling ticks between consecutive bit ticks are counted.

// File: rtl/baud_div_pkg.sv
package baud_div_pkg;
  // strobes from register control to the counting datapath
  typedef struct packed {
    logic countEn;     // generator armed and divisor nonzero
    logic divWritten;  // active divisor updated this cycle
  } divStrobe_t;
endpackage

// File: rtl/baud_div_ctrl.sv
module baud_div_ctrl
  import baud_div_pkg::*;
#(
  parameter int DIV_W     = 13,
  parameter int BYTE_W    = 8,
  parameter int RESET_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              rdSel,
  output logic [BYTE_W-1:0] rdData,
  input  logic              txEnable,
  input  logic              rxEnable,
  output logic [DIV_W-1:0]  divisor,
  output divStrobe_t        strobe
);
  localparam int HI_W  = DIV_W - BYTE_W;
  localparam int PAD_W = BYTE_W - HI_W;

  logic [HI_W-1:0]  holdHi;
  logic [DIV_W-1:0] activeDiv;
  logic             armed;
  logic             loadLo;

  assign loadLo = wrEn && wrSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdHi    <= '0;
      activeDiv <= DIV_W'(RESET_DIV);
      armed     <= 1'b0;
    end else begin
      if (wrEn && !wrSel) holdHi <= wrData[HI_W-1:0];
      if (loadLo) activeDiv <= {holdHi, wrData};
      if (txEnable || rxEnable) armed <= 1'b1;
    end
  end

  always_comb begin
    if (rdSel) rdData = activeDiv[BYTE_W-1:0];
    else       rdData = {{PAD_W{1'b0}}, activeDiv[DIV_W-1:BYTE_W]};
  end

  assign divisor           = activeDiv;
  assign strobe.countEn    = armed && (activeDiv != '0);
  assign strobe.divWritten = loadLo;

  assert_hold_only_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrSel) |=> $stable(activeDiv));

  assert_armed_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    armed |=> armed);
endmodule

// File: rtl/baud_div_dp.sv
module baud_div_dp
  import baud_div_pkg::*;
#(
  parameter int DIV_W      = 13,
  parameter int OVERSAMPLE = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  divStrobe_t       strobe,
  input  logic [DIV_W-1:0] divisor,
  output logic             overTick,
  output logic             bitTick
);
  localparam int SUB_W = $clog2(OVERSAMPLE);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVERSAMPLE - 1);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] period;
  logic [DIV_W-1:0] curLimit;
  logic [SUB_W-1:0] sub;
  logic             running;
  logic             wrap;

  // first counting cycle uses the live divisor, later ones the latched period
  assign curLimit = running ? period : divisor;
  assign wrap     = strobe.countEn && (cnt == curLimit - DIV_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      period   <= '0;
      sub      <= '0;
      running  <= 1'b0;
      overTick <= 1'b0;
      bitTick  <= 1'b0;
    end else if (!strobe.countEn) begin
      cnt      <= '0;
      sub      <= '0;
      running  <= 1'b0;
      overTick <= 1'b0;
      bitTick  <= 1'b0;
    end else begin
      running <= 1'b1;
      if (!running) period <= divisor;
      if (wrap) begin
        cnt      <= '0;
        period   <= divisor;
        overTick <= 1'b1;
        bitTick  <= (sub == SUB_LAST);
        sub      <= (sub == SUB_LAST) ? '0 : sub + SUB_W'(1);
      end else begin
        cnt      <= cnt + DIV_W'(1);
        overTick <= 1'b0;
        bitTick  <= 1'b0;
      end
    end
  end

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.countEn |=> (!overTick && !bitTick));

  assert_bit_with_over_R7: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |-> overTick);

  assert_no_glitch_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.divWritten && running && !wrap) |=> $stable(period));
endmodule

// File: rtl/baud_div.sv
module baud_div
  import baud_div_pkg::*;
#(
  parameter int DIV_W      = 13,
  parameter int BYTE_W     = 8,
  parameter int OVERSAMPLE = 16,
  parameter int RESET_DIV  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              rdSel,
  output logic [BYTE_W-1:0] rdData,
  input  logic              txEnable,
  input  logic              rxEnable,
  output logic              overTick,
  output logic              bitTick
);
  divStrobe_t       strobe;
  logic [DIV_W-1:0] divisor;

  baud_div_ctrl #(.DIV_W(DIV_W), .BYTE_W(BYTE_W), .RESET_DIV(RESET_DIV)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .txEnable(txEnable), .rxEnable(rxEnable),
    .divisor(divisor), .strobe(strobe)
  );

  baud_div_dp #(.DIV_W(DIV_W), .OVERSAMPLE(OVERSAMPLE)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .divisor(divisor),
    .overTick(overTick), .bitTick(bitTick)
  );
endmodule

// File: tb/baud_div_test.sv
`timescale 1ns/1ps
module baud_div_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, wrSel = 1'b0, rdSel = 1'b0;
  logic [7:0] wrData = '0;
  logic txEnable = 1'b0, rxEnable = 1'b0;
  logic [7:0] rdData;
  logic overTick, bitTick;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  baud_div uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .txEnable(txEnable), .rxEnable(rxEnable),
    .overTick(overTick), .bitTick(bitTick)
  );

  // {sel, data, expected high read, expected low read}
  localparam logic [24:0] VEC [0:6] = '{
    {1'b0, 8'h1F, 8'h00, 8'h04},  // R2 staged only
    {1'b1, 8'hFF, 8'h1F, 8'hFF},  // R3 both bytes land
    {1'b0, 8'hE3, 8'h1F, 8'hFF},  // R2 staged only
    {1'b1, 8'h10, 8'h03, 8'h10},  // R3 upper bits dropped
    {1'b1, 8'h22, 8'h03, 8'h22},  // R9 holding reused
    {1'b0, 8'h00, 8'h03, 8'h22},  // R2
    {1'b1, 8'h03, 8'h00, 8'h03}   // R3 divisor 3
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic sel, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic readReg(input logic sel, output int v);
    rdSel = sel; #0.5; v = int'(rdData);
  endtask

  task automatic nextGap(output int gap);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!overTick && gap < 10000);
  endtask

  task automatic waitTick();
    int g;
    nextGap(g);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int v, g, n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    readReg(1'b1, v); check("R1 low", v, 8'h04);
    readReg(1'b0, v); check("R1 high", v, 8'h00);
    // R5 no ticks before enable
    n = 0;
    repeat (30) begin @(negedge clk); if (overTick || bitTick) n++; end
    check("R5 idle before enable", n, 0);

    foreach (VEC[i]) begin
      writeReg(VEC[i][24], VEC[i][23:16]);
      readReg(1'b0, v); check("R2/R3/R9 high readback", v, int'(VEC[i][15:8]));
      readReg(1'b1, v); check("R2/R3/R9 low readback", v, int'(VEC[i][7:0]));
    end

    n = 0;
    repeat (20) begin @(negedge clk); if (overTick) n++; end
    check("R5 still idle", n, 0);

    // arm with a single-cycle receiver enable, then drop it
    @(negedge clk); rxEnable = 1'b1;
    @(negedge clk); rxEnable = 1'b0;
    waitTick();
    check("R4 pulse width", int'(overTick), 1);
    @(negedge clk); check("R4 one clock", int'(overTick), 0);
    waitTick();
    nextGap(g); check("R4/R5 gap div3", g, 3);

    // R7: 16 overTicks per bitTick, bitTick only with overTick
    do @(negedge clk); while (!bitTick);
    n = 0; v = 0;
    do begin
      @(negedge clk);
      if (overTick) n++;
      if (bitTick && !overTick) v++;
    end while (!bitTick);
    check("R7 overTicks per bitTick", n, 16);
    check("R7 bitTick alone", v, 0);

    // R8: write divisor 7 sampled on the wrap edge
    waitTick();
    @(negedge clk); @(negedge clk);
    wrEn = 1'b1; wrSel = 1'b1; wrData = 8'h07;
    @(negedge clk); wrEn = 1'b0;
    check("R8 tick on wrap", int'(overTick), 1);
    nextGap(g); check("R8 old period kept", g, 3);
    nextGap(g); check("R8 new period", g, 7);

    // R4 divisor 1
    writeReg(1'b1, 8'h01);
    waitTick(); waitTick();
    n = 0;
    repeat (10) begin @(negedge clk); if (overTick) n++; end
    check("R4 div1 every clock", n, 10);

    // R6 divisor zero
    writeReg(1'b1, 8'h00);
    n = 0;
    repeat (40) begin @(negedge clk); if (overTick || bitTick) n++; end
    check("R6 zero divisor", n, 0);

    // R5 stays armed with enables low
    writeReg(1'b1, 8'h05);
    waitTick();
    nextGap(g); check("R5 sticky arm gap5", g, 5);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule